// File: doc/BRIEF.md
# TDM Time-Slot Serial Transmitter

This block moves bytes from a byte FIFO onto a serial link, least significant bit first, one bit for each launch edge of a bit clock. In highway mode the link is a TDM frame. A frame-sync pulse anchors bit position zero, and a position counter wraps after a programmable frame length. Only one 8-bit slot is used. An 8-bit mask inside that slot chooses which bit positions carry user data, so the effective rate can be set from one eighth to the full slot. In non-highway mode frame sync is ignored and every launch edge carries a bit.

Two output pins, A and B, each have a data line and an output-enable. The output-enable stands in for a tri-state driver. Configuration decides per pin whether the pin is released, sends idle ones, or sends user data. An active-low strobe marks the data-carrying bits of the slot on pin A. The whole block runs on a single system clock. The bit clock is sampled, and its rising or falling edge is chosen as the launch edge. A serializer reset clears the partly sent byte and the underrun flag without touching the frame position.

Top module: `tdm_slot_tx`

## Requirements
- R1: During and right after reset, both output-enables are 0, `slot_n` is 1, `fifo_ready` is 0 and `underrun` is 0.
- R2: Bits leave LSB first, one per launch edge. A new byte is taken (`fifo_ready` and `fifo_valid` both 1 in one clock) only when a data bit is needed and all 8 bits of the previous byte have been sent.
- R3: With `edge_pos` = 0 a falling edge of `bclk` launches a bit. With `edge_pos` = 1 a rising edge launches it. The other edge has no effect.
- R4: With `hwy_en` = 0, `fs_in` is ignored and every launch edge sends a bit on each selected pin. If `tx_en` is also 0, both output-enables are 0.
- R5: `fs_in` is active high when `fs_pol` = 1 and active low when it is 0. After an active edge of frame sync, the next launched bit is position 0. Without a new sync, position `frame_len` (frame bits minus one) is followed by position 0.
- R6: In highway mode, bit position p carries data only if sync has been seen, p>>3 equals `slot_num`, and `bit_mask[p%8]` = 1. Selected pins are enabled on exactly those bits and released on all other bits.
- R7: `slot_n` is 0 exactly on the data-carrying bits of R6, and only when `hwy_en` = 1 and `sel_a` = 1.
- R8: With `hwy_en` = 1 and `tx_en` = 0, selected pins send 1 on data-carrying bits and the FIFO is not read. Disabling keeps the serializer state, so after re-enabling, the partly sent byte continues.
- R9: With `tx_en` = 1 and neither pin selected, both pins are released and the FIFO still drains at the normal bit rate.
- R10: If a data bit is needed and the FIFO is empty, the bit sent is 1 and `underrun` is set. The flag stays set until a serializer reset.
- R11: A one-clock pulse on `ser_rst` clears `underrun` and discards the rest of the current byte. The next data bit is bit 0 of a freshly fetched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_rst | input | 1 | Serializer reset pulse |
| bclk | input | 1 | Sampled transmit bit clock |
| edge_pos | input | 1 | 1: rising launch edge, 0: falling |
| fs_in | input | 1 | Frame sync |
| fs_pol | input | 1 | 1: frame sync active high |
| hwy_en | input | 1 | 1: TDM highway mode |
| frame_len | input | FW | Frame length in bits minus one |
| slot_num | input | FW-3 | Selected slot index |
| bit_mask | input | 8 | Data-carrying positions within the slot |
| tx_en | input | 1 | Transmitter enable |
| sel_a | input | 1 | Pin A select |
| sel_b | input | 1 | Pin B select |
| fifo_data | input | 8 | FIFO head byte |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_ready | output | 1 | Byte taken this clock when valid |
| txd_a | output | 1 | Pin A data |
| txd_a_oe | output | 1 | Pin A output-enable |
| txd_b | output | 1 | Pin B data |
| txd_b_oe | output | 1 | Pin B output-enable |
| slot_n | output | 1 | Slot data strobe, active low |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The assertions assume that `bclk` is stable around each system clock edge. They also assume that `edge_pos` and the other configuration inputs change only while reset is held, so that a launch seen at the ports always matches the edge selected at that time. The bench drives `bclk`, `fs_in` and `tx_en` on falling system clock edges, changes the configuration only inside its reset task, and keeps each bit-clock half period at least one system clock long. The checks on strobe and pin timing therefore follow from the frame position alone.

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_rst,
  input  logic          bclk,
  input  logic          edge_pos,
  input  logic          fs_in,
  input  logic          fs_pol,
  input  logic          hwy_en,
  input  logic [FW-1:0] frame_len,
  input  logic [FW-4:0] slot_num,
  input  logic [7:0]    bit_mask,
  input  logic          tx_en,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic [7:0]    fifo_data,
  input  logic          fifo_valid,
  output logic          fifo_ready,
  output logic          txd_a,
  output logic          txd_a_oe,
  output logic          txd_b,
  output logic          txd_b_oe,
  output logic          slot_n,
  output logic          underrun
);
  localparam int SW = FW - 3;

  logic          bclk_q, fs_q, fs_pend, synced, act_q, dout_q, urun_q;
  logic [FW-1:0] pos, nxt_pos;
  logic [7:0]    sh;
  logic [2:0]    left;
  logic          nxt_sync, nxt_act;

  wire launch  = (bclk != bclk_q) && (bclk == edge_pos);
  wire fs_lvl  = fs_pol ? fs_in : ~fs_in;
  wire fs_edge = hwy_en && fs_lvl && !fs_q;
  wire fs_hit  = hwy_en && (fs_pend || fs_edge);
  wire need    = launch && nxt_act && tx_en;
  wire have    = (left != 3'd0);

  always_comb begin
    if (fs_hit)                nxt_pos = '0;
    else if (pos == frame_len) nxt_pos = '0;
    else                       nxt_pos = pos + 1'b1;
    nxt_sync = synced || fs_hit;
    nxt_act  = hwy_en ? (nxt_sync && (nxt_pos[FW-1:3] == slot_num[SW-1:0])
                         && bit_mask[nxt_pos[2:0]]) : 1'b1;
  end

  assign fifo_ready = need && !have;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= bclk;
      fs_q    <= fs_lvl;
      fs_pend <= 1'b0;
      synced  <= 1'b0;
      pos     <= '0;
      act_q   <= 1'b0;
    end else begin
      bclk_q <= bclk;
      fs_q   <= fs_lvl;
      if (launch) begin
        fs_pend <= 1'b0;
        pos     <= nxt_pos;
        synced  <= nxt_sync;
        act_q   <= nxt_act;
      end else if (fs_edge) begin
        fs_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ser_rst) begin
      sh     <= '0;
      left   <= '0;
      dout_q <= 1'b1;
      urun_q <= 1'b0;
    end else if (launch) begin
      if (!need) begin
        dout_q <= 1'b1;
      end else if (have) begin
        dout_q <= sh[0];
        sh     <= sh >> 1;
        left   <= left - 1'b1;
      end else if (fifo_valid) begin
        dout_q <= fifo_data[0];
        sh     <= {1'b0, fifo_data[7:1]};
        left   <= 3'd7;
      end else begin
        dout_q <= 1'b1;
        urun_q <= 1'b1;
      end
    end
  end

  wire drive = act_q && (hwy_en || tx_en);

  assign txd_a    = dout_q;
  assign txd_b    = dout_q;
  assign txd_a_oe = sel_a && drive;
  assign txd_b_oe = sel_b && drive;
  assign slot_n   = !(hwy_en && sel_a && act_q);
  assign underrun = urun_q;
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_rst,
  input logic tx_en,
  input logic bclk,
  input logic edge_pos,
  input logic fifo_ready,
  input logic txd_a_oe,
  input logic slot_n,
  input logic underrun
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!txd_a_oe && slot_n && !underrun && !fifo_ready));

  assert_pop_on_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> ((bclk == edge_pos) && (bclk != $past(bclk))));

  assert_strobe_on_pin_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_n |-> txd_a_oe);

  assert_no_pop_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !fifo_ready);

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !ser_rst) |=> underrun);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_rst(ser_rst), .tx_en(tx_en),
  .bclk(bclk), .edge_pos(edge_pos), .fifo_ready(fifo_ready),
  .txd_a_oe(txd_a_oe), .slot_n(slot_n), .underrun(underrun)
);

// File: tb/tdm_slot_tx_test.sv
module tdm_slot_tx_test;
  localparam int FW = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ser_rst = 1'b0, bclk = 1'b1, edge_pos = 1'b0;
  logic fs_in = 1'b0, fs_pol = 1'b1, hwy_en = 1'b0;
  logic [FW-1:0] frame_len = '0;
  logic [FW-4:0] slot_num = '0;
  logic [7:0] bit_mask = 8'hFF;
  logic tx_en = 1'b0, sel_a = 1'b0, sel_b = 1'b0;
  logic [7:0] fifo_data;
  logic fifo_valid, fifo_ready;
  logic txd_a, txd_a_oe, txd_b, txd_b_oe, slot_n, underrun;

  logic [7:0] q [16];
  int hd, tl, ep, eb;
  int nchk = 0, nbad = 0;

  assign fifo_valid = (hd != tl);
  assign fifo_data  = q[hd % 16];

  always @(posedge clk)
    if (!rst_n) hd <= 0;
    else if (fifo_ready && fifo_valid) hd <= hd + 1;

  tdm_slot_tx #(.FW(FW)) uut (
    .clk(clk), .rst_n(rst_n), .ser_rst(ser_rst), .bclk(bclk), .edge_pos(edge_pos),
    .fs_in(fs_in), .fs_pol(fs_pol), .hwy_en(hwy_en), .frame_len(frame_len),
    .slot_num(slot_num), .bit_mask(bit_mask), .tx_en(tx_en), .sel_a(sel_a),
    .sel_b(sel_b), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .txd_a(txd_a), .txd_a_oe(txd_a_oe), .txd_b(txd_b),
    .txd_b_oe(txd_b_oe), .slot_n(slot_n), .underrun(underrun)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic push(logic [7:0] v);
    q[tl % 16] = v;
    tl++;
  endtask

  task automatic exp_bit(output logic b);
    b = q[ep % 16][eb];
    eb++;
    if (eb == 8) begin eb = 0; ep++; end
  endtask

  task automatic do_reset(logic hw, logic pol, logic epos, logic en, logic sa, logic sb,
                          int flen, int slot, logic [7:0] msk);
    @(negedge clk);
    rst_n = 1'b0;
    hwy_en = hw; fs_pol = pol; edge_pos = epos; tx_en = en; sel_a = sa; sel_b = sb;
    frame_len = FW'(flen); slot_num = (FW-3)'(slot); bit_mask = msk;
    fs_in = ~pol; bclk = ~epos; ser_rst = 1'b0;
    tl = 0; ep = 0; eb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic launch();
    @(negedge clk) bclk = ~edge_pos;
    @(negedge clk) bclk = edge_pos;
    @(negedge clk);
  endtask

  task automatic pulse_fs();
    @(negedge clk) fs_in = fs_pol;
    @(negedge clk) fs_in = ~fs_pol;
  endtask

  task automatic t_reset();
    do_reset(0, 1, 0, 0, 0, 0, 0, 0, 8'hFF);
    @(negedge clk);
    check("R1 oe_a", txd_a_oe, 0);
    check("R1 oe_b", txd_b_oe, 0);
    check("R1 slot_n", slot_n, 1);
    check("R1 ready", fifo_ready, 0);
    check("R1 underrun", underrun, 0);
  endtask

  task automatic t_stream();
    logic b;
    do_reset(0, 1, 0, 1, 1, 0, 0, 0, 8'hFF);
    push(8'hA5); push(8'h3C);
    for (int i = 0; i < 16; i++) begin
      if (i == 5) pulse_fs();
      launch();
      exp_bit(b);
      check("R2 lsb first data", txd_a, b);
      check("R4 pin a driven", txd_a_oe, 1);
      check("R4 pin b released", txd_b_oe, 0);
      check("R4 no strobe", slot_n, 1);
    end
    check("R2 two bytes taken", hd, 2);
    check("R3 falling edge count", underrun, 0);
    @(negedge clk) tx_en = 1'b0;
    launch();
    check("R4 disabled a", txd_a_oe, 0);
    check("R4 disabled b", txd_b_oe, 0);
  endtask

  task automatic t_edge();
    logic b;
    do_reset(0, 1, 1, 1, 1, 0, 0, 0, 8'hFF);
    push(8'h96);
    for (int i = 0; i < 8; i++) begin
      launch();
      exp_bit(b);
      check("R3 rising edge data", txd_a, b);
    end
    check("R3 one byte", hd, 1);
    check("R3 falling ignored", underrun, 0);
  endtask

  task automatic t_slot(logic pol, logic sa, int frames);
    logic b, act;
    do_reset(1, pol, 0, 1, sa, 1, 31, 2, 8'b0110_1001);
    push(8'hC3); push(8'h5A);
    for (int i = 0; i < 4; i++) begin
      launch();
      check("R6 unsynced released", txd_b_oe, 0);
      check("R7 unsynced strobe", slot_n, 1);
    end
    pulse_fs();
    for (int f = 0; f < frames; f++) begin
      for (int p = 0; p < 32; p++) begin
        launch();
        act = ((p >> 3) == 2) && bit_mask[p % 8];
        check("R6 pin b enable", txd_b_oe, act);
        check("R6 pin a enable", txd_a_oe, act && sa);
        check("R7 strobe", slot_n, !(act && sa));
        if (act) begin
          exp_bit(b);
          check("R5 slot data", txd_b, b);
        end
      end
      if (f == 0) check("R2 no early fetch", hd, 1);
    end
  endtask

  task automatic t_disabled();
    logic b, act;
    do_reset(1, 1, 0, 0, 1, 1, 31, 2, 8'b0110_1001);
    push(8'h00);
    pulse_fs();
    for (int p = 0; p < 32; p++) begin
      launch();
      act = ((p >> 3) == 2) && bit_mask[p % 8];
      check("R8 enable", txd_a_oe, act);
      if (act) check("R8 idle ones", txd_a, 1);
    end
    check("R8 fifo untouched", hd, 0);
    do_reset(0, 1, 0, 1, 1, 0, 0, 0, 8'hFF);
    push(8'hE1);
    for (int i = 0; i < 3; i++) begin launch(); exp_bit(b); check("R8 before pause", txd_a, b); end
    @(negedge clk) tx_en = 1'b0;
    for (int i = 0; i < 4; i++) begin launch(); check("R8 paused", txd_a_oe, 0); end
    @(negedge clk) tx_en = 1'b1;
    for (int i = 0; i < 5; i++) begin launch(); exp_bit(b); check("R8 resumed", txd_a, b); end
    check("R8 single fetch", hd, 1);
    check("R8 no underrun", underrun, 0);
  endtask

  task automatic t_nosel();
    do_reset(0, 1, 0, 1, 0, 0, 0, 0, 8'hFF);
    push(8'h12); push(8'h34);
    for (int i = 0; i < 16; i++) begin
      launch();
      check("R9 a released", txd_a_oe, 0);
      check("R9 b released", txd_b_oe, 0);
    end
    check("R9 drained", hd, 2);
    check("R9 no underrun", underrun, 0);
  endtask

  task automatic t_underrun();
    do_reset(0, 1, 0, 1, 1, 0, 0, 0, 8'hFF);
    launch();
    check("R10 idle bit", txd_a, 1);
    check("R10 flag", underrun, 1);
    push(8'hF0);
    for (int i = 0; i < 3; i++) begin
      launch();
      check("R10 data after", txd_a, 0);
      check("R10 sticky", underrun, 1);
    end
    @(negedge clk) ser_rst = 1'b1;
    @(negedge clk) ser_rst = 1'b0;
    check("R11 flag cleared", underrun, 0);
    push(8'h0F);
    launch();
    check("R11 fresh byte bit0", txd_a, 1);
    check("R11 fetched", hd, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_edge();
    t_slot(1'b0, 1'b1, 3);
    t_slot(1'b1, 1'b0, 1);
    t_disabled();
    t_nosel();
    t_underrun();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule